// File: doc/BRIEF.md
# Homeostatic Threshold Tuner

This block keeps a spiking neuron firing at a steady rate when some of its excitatory synapses go quiet. Each clock cycle it receives the number of excitatory synapses that are injecting current into the neuron. It tracks the largest such count over a fixed observation window and sorts that peak into one of seven current bands. At the end of the window it compares the band with the band of the previous window.

When the band has changed, the block drives a new firing threshold for the neuron and pulses a strobe for one cycle. A lower band gives a lower threshold. When inputs are lost, the neuron therefore needs less charge to fire, and its spike rate recovers. When the band stays the same, the threshold does not move, so noise inside one band causes no rewrites.

The threshold is a 32-bit value in microvolts. It equals a 15000 µV standard threshold scaled by a per-band factor of (band+2)/8, so the factor runs from 0.25 for band 0 to 1.0 for band 6.

Top module: `homeo_thresh_tuner`

## Requirements
- R1: While reset is held, `thr_out` is 15000 and `thr_upd` is 0. The remembered previous band is band 6, so a neuron with all inputs working causes no update after reset.
- R2: An observation window lasts 40 cycles and the first window starts on the first clock edge after reset is released. `thr_upd` is 0 on every cycle except the one that follows the last cycle of a window.
- R3: The window peak is the largest `cur_cnt` value sampled in any of the window's 40 cycles, including the first and the last.
- R4: The peak restarts with every window. A value seen in an earlier window has no effect on the band of a later window.
- R5: The band of a peak P is found from the edges 9, 18, 27, 36, 45 and 54:
  - band 0 when P < 9
  - band 1 when 9 ≤ P < 18
  - band 2 when 18 ≤ P < 27
  - band 3 when 27 ≤ P < 36
  - band 4 when 36 ≤ P < 45
  - band 5 when 45 ≤ P < 54
  - band 6 when P ≥ 54, which includes values above 60.
- R6: The threshold for band b is 15000·(b+2)/8: 3750, 5625, 7500, 9375, 11250, 13125 and 15000 for bands 0 to 6.
- R7: When a window's band equals the band of the previous window, `thr_out` keeps its value and `thr_upd` stays 0.
- R8: When a window's band differs from the previous band, `thr_out` takes the new band's threshold and `thr_upd` is 1. Both appear on the clock edge right after the window's last sample.
- R9: `thr_upd` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_cnt | input | 7 | Number of excitatory synapses injecting current in this cycle |
| thr_out | output | 32 | Neuron firing threshold in microvolts |
| thr_upd | output | 1 | One-cycle pulse when a new threshold is driven |

## Verification
Most windows drive a flat level, and these levels sit on both sides of each band edge, for example 8 against 9, 17 against 18, and 53 against 54. They separate correct band boundaries from off-by-one comparisons, and they confirm every entry of the threshold table.

Other windows hold a single spike over a low base level. The spike is placed in the first cycle, in the middle and in the last cycle, which shows whether every sample of the window is included in the peak. A large spike followed by a window with a lower flat level shows whether the running maximum restarts at the window boundary. Pairs of windows in the same band, but with different peaks, separate band-change detection from simple value-change detection.

// File: rtl/homeo_thresh_tuner.sv
module homeo_thresh_tuner #(
  parameter int CUR_W     = 7,
  parameter int WIN_LEN   = 40,
  parameter int NB        = 7,
  parameter int EDGE_STEP = 9,
  parameter int STD_THR   = 15000,
  parameter int R_DEN     = 8,
  parameter int THR_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CUR_W-1:0] cur_cnt,
  output logic [THR_W-1:0] thr_out,
  output logic             thr_upd
);

  localparam int CNT_W  = $clog2(WIN_LEN);
  localparam int BAND_W = $clog2(NB);
  localparam int TAB_N  = 1 << BAND_W;
  localparam int R_BASE = R_DEN - NB + 1;
  localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NB - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0]  win_cnt;
  logic [CUR_W-1:0]  run_max;
  logic [CUR_W-1:0]  peak_now;
  logic [BAND_W-1:0] prev_band;
  logic [BAND_W-1:0] band_now;
  logic [NB-1:1]     above;
  logic [THR_W-1:0]  thr_tab [TAB_N];
  logic              win_end;

  assign win_end = (win_cnt == LAST_CNT);

  // The first sample of a window replaces the old maximum instead of being compared with it.
  assign peak_now = (win_cnt == '0)       ? cur_cnt :
                    (cur_cnt > run_max)    ? cur_cnt : run_max;

  for (genvar g = 1; g < NB; g++) begin : g_edge
    assign above[g] = (32'(peak_now) >= 32'(g * EDGE_STEP));
  end

  always_comb begin
    band_now = '0;
    for (int i = 1; i < NB; i++) band_now = band_now + BAND_W'(above[i]);
  end

  for (genvar b = 0; b < TAB_N; b++) begin : g_tab
    if (b < NB) begin : g_used
      assign thr_tab[b] = THR_W'((STD_THR * (b + R_BASE)) / R_DEN);
    end else begin : g_spare
      assign thr_tab[b] = THR_W'(STD_THR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      run_max   <= '0;
      prev_band <= TOP_BAND;
      thr_out   <= THR_W'(STD_THR);
      thr_upd   <= 1'b0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      run_max <= peak_now;
      thr_upd <= 1'b0;
      if (win_end) begin
        prev_band <= band_now;
        if (band_now != prev_band) begin
          thr_out <= thr_tab[band_now];
          thr_upd <= 1'b1;
        end
      end
    end
  end

  // R2
  upd_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    thr_upd |-> (win_cnt == '0));

  // R7
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_upd |-> $stable(thr_out));

  // R8
  upd_moves_thr_chk: assert property (@(posedge clk) disable iff (rst)
    thr_upd |-> (thr_out != $past(thr_out)));

  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (rst)
    thr_upd |=> !thr_upd);

  // R6
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_out >= THR_W'((STD_THR * R_BASE) / R_DEN)) && (thr_out <= THR_W'(STD_THR)));

endmodule

// File: tb/homeo_thresh_tuner_test.sv
module homeo_thresh_tuner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  cur_cnt = '0;
  logic [31:0] thr_out;
  logic        thr_upd;

  int n_chk  = 0;
  int n_fail = 0;

  homeo_thresh_tuner uut (
    .clk(clk), .rst(rst), .cur_cnt(cur_cnt),
    .thr_out(thr_out), .thr_upd(thr_upd)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // Drives one 40-cycle window: base level everywhere, spike at position pos.
  // Starts and ends on a falling edge; at the end the window result is visible.
  task automatic run_window(input string req, input int base, input int spike,
                            input int pos, input int exp_thr, input int exp_upd);
    int mid_upd = 0;
    for (int i = 0; i < 40; i++) begin
      cur_cnt = 7'((i == pos) ? spike : base);
      @(negedge clk);
      if (i < 39 && thr_upd) mid_upd++;
    end
    check({req, " R2 R9 strobe inside window"}, mid_upd, 0);
    check({req, " threshold"}, int'(thr_out), exp_thr);
    check({req, " strobe"}, int'(thr_upd), exp_upd);
  endtask

  task automatic reset_test();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset threshold", int'(thr_out), 15000);
    check("R1 reset strobe", int'(thr_upd), 0);
    rst = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    reset_test();
    run_window("R1 R7 healthy top band",        60, 60, 0, 15000, 0);
    run_window("R5 R6 R8 band4 mid spike",       5, 40, 20, 11250, 1);
    run_window("R3 R7 same band first-cycle",    0, 36, 0, 11250, 0);
    run_window("R5 R6 R8 flat 8 band0",          8,  8, 0,  3750, 1);
    run_window("R3 R5 last-cycle 9 band1",       0,  9, 39, 5625, 1);
    run_window("R3 R6 first-cycle 60 band6",     0, 60, 0, 15000, 1);
    run_window("R4 restart flat 20 band2",      20, 20, 0,  7500, 1);
    run_window("R5 over-range 127 band6",        0,127, 10, 15000, 1);
    run_window("R5 R6 flat 53 band5",           53, 53, 0, 13125, 1);
    run_window("R5 flat 54 band6",              54, 54, 0, 15000, 1);
    run_window("R5 R6 flat 17 band1",           17, 17, 0,  5625, 1);
    run_window("R5 flat 18 band2",              18, 18, 0,  7500, 1);
    run_window("R5 R6 flat 27 band3",           27, 27, 0,  9375, 1);
    run_window("R7 flat 35 still band3",        35, 35, 0,  9375, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule